// File: doc/BRIEF.md
# SEC-DED Protected Word Memory

This block is a synchronous word store for 32-bit data that protects every location with a single-error-correcting, double-error-detecting code. Each word written through the request port is stored with six Hamming check bits and one overall parity bit. Each read through that port decodes the stored word. A single flipped bit is corrected in the returned data. Two flipped bits are detected and reported. A location that has not been written since reset counts as uncorrectable.

A sticky error flag reports one class of event, chosen by a configuration input. With the mode input low, the flag reports uncorrectable words. With the mode input high, it reports corrected single-bit words. Reads of unwritten locations raise the flag in both modes. Once the flag is high, only a later decoded read that finds a clean word clears it.

A second port serves a scrubber. A scrub access reads one location and checks it. When the location holds a single-bit error, the corrected word is written back in the same cycle. A bypass input turns off the code entirely. In bypass, writes store raw data and leave the stored check bits untouched, reads return raw data, and scrub accesses do nothing. The address width is a parameter: the full configuration uses 19 bits, and the default is small enough to simulate.

Top module: `ecc_word_mem`

## Requirements
- R1: A request with `req_en`=1 and `req_wr`=1 stores `req_wdata` at `req_addr`. A later decoded read of that address (`req_en`=1, `req_wr`=0, `cfg_bypass`=0) drives the same word on `rd_data` after the next rising clock edge. `rd_data` holds its value until the next read, and it is 0 after reset.
- R2: When exactly one stored data bit differs from the encoded word, a decoded read returns the originally encoded data.
- R3: With `cfg_mode_sbe`=0, a decoded read of a word with two flipped bits sets `err_flag` after the next edge. A single-bit word read in this mode leaves `err_flag` unchanged.
- R4: With `cfg_mode_sbe`=1, a decoded read of a single-bit word sets `err_flag`. A double-bit word read in this mode leaves `err_flag` unchanged.
- R5: A decoded read of a location not written since reset sets `err_flag` in either mode and returns 0 on `rd_data`.
- R6: `err_flag` is 0 after reset and stays high once set. Only a decoded read of a clean word clears it, after the next edge. Idle cycles and reads of the non-selected error kind leave it high.
- R7: With `cfg_bypass`=1, a write replaces only the data bits and keeps the stored check bits. A read returns the raw stored data (0 for an unwritten location) and leaves `err_flag` unchanged.
- R8: A scrub access (`scr_en`=1) to a single-bit word writes the corrected word back and pulses `scr_fixed` for one cycle after the edge. A later read finds the word clean. In mode 1 the access also sets `err_flag`.
- R9: A scrub access to a double-bit or unwritten word pulses `scr_fault` and leaves the stored word unchanged. It sets `err_flag` for an unwritten word in either mode, and for a double-bit word in mode 0.
- R10: A scrub access has no effect while `req_en`=1 or `cfg_bypass`=1: no pulse, no write-back and no flag change.
- R11: A decoded read of a double-bit word returns the stored data bits uncorrected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; clears the valid bits, the flag and the outputs |
| cfg_mode_sbe | input | 1 | Flag meaning: 0 = uncorrectable words, 1 = corrected single-bit words |
| cfg_bypass | input | 1 | 1 = code disabled: raw writes, raw reads, no scrubbing |
| req_en | input | 1 | Request port access strobe |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request port word address |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| err_flag | output | 1 | Sticky error flag |
| scr_en | input | 1 | Scrub access strobe |
| scr_addr | input | ADDR_W | Scrub word address |
| scr_fixed | output | 1 | One-cycle pulse: a single-bit word was corrected and written back |
| scr_fault | output | 1 | One-cycle pulse: the scrubbed word was uncorrectable or unwritten |

## Verification
Every result is registered once, so `rd_data`, `err_flag`, `scr_fixed` and `scr_fault` are due exactly one rising edge after the cycle that carries the request. Repairs made by a scrub access first show up on the read that follows. The bench applies each request at a falling edge and predicts the four outputs for after the next rising edge. It compares them at the following falling edge, away from the edge that updates them. Bit errors are injected only through bypass writes, so the reference model can find the error weight of each word from the data it last encoded and the raw data it last stored.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int DATA_W = 32;

  function automatic int ham_bits_for(input int dw);
    int r;
    r = 1;
    while ((2 ** r) < (dw + r + 1)) r++;
    return r;
  endfunction

  localparam int HAM_W   = ham_bits_for(DATA_W);
  localparam int CHK_W   = HAM_W + 1;
  localparam int POS_MAX = DATA_W + HAM_W;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [CHK_W-1:0]  chk_t;
  typedef logic [HAM_W-1:0]  syn_t;

  // codeword position of data bit idx: positions 1..POS_MAX that are not powers of two
  function automatic syn_t data_pos(input int idx);
    int   cnt;
    syn_t r;
    cnt = 0;
    r   = '0;
    for (int p = 1; p <= POS_MAX; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx) r = syn_t'(p);
        cnt++;
      end
    end
    return r;
  endfunction

  // XOR of the positions of all set data bits
  function automatic syn_t ham_syn(input word_t d);
    syn_t s;
    s = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (d[i]) s = s ^ data_pos(i);
    end
    return s;
  endfunction

  // stored check field: {overall parity, Hamming bits}
  function automatic chk_t ecc_check(input word_t d);
    syn_t s;
    s = ham_syn(d);
    return {(^d) ^ (^s), s};
  endfunction
endpackage

// File: rtl/ecc_word_decode.sv
module ecc_word_decode
  import ecc_pkg::*;
(
  input  word_t st_data,
  input  chk_t  st_chk,
  input  logic  st_valid,
  output word_t fix_data,
  output logic  evt_clean,
  output logic  evt_single,
  output logic  evt_multi,
  output logic  evt_invalid
);
  syn_t  syn;
  logic  par;
  logic  in_range;
  logic  single_ok;
  word_t flipped;

  always_comb begin
    syn      = ham_syn(st_data) ^ st_chk[HAM_W-1:0];
    par      = (^st_data) ^ (^st_chk);
    in_range = (int'(syn) <= POS_MAX);
    flipped  = st_data;
    for (int i = 0; i < DATA_W; i++) begin
      if (data_pos(i) == syn) flipped[i] = ~st_data[i];
    end
    single_ok   = par && in_range;
    evt_invalid = !st_valid;
    evt_clean   = st_valid && !par && (syn == '0);
    evt_single  = st_valid && single_ok;
    evt_multi   = st_valid && !par && (syn != '0) || st_valid && par && !in_range;
    if (!st_valid)      fix_data = '0;
    else if (single_ok) fix_data = flipped;
    else                fix_data = st_data;
  end
endmodule

// File: rtl/ecc_word_store.sv
module ecc_word_store
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int DEPTH = 2 ** ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wa_en,
  input  logic [ADDR_W-1:0] wa_addr,
  input  word_t             wa_data,
  input  chk_t              wa_chk,
  input  logic              wa_keep_chk,
  input  logic              wb_en,
  input  logic [ADDR_W-1:0] wb_addr,
  input  word_t             wb_data,
  input  chk_t              wb_chk,
  input  logic [ADDR_W-1:0] ra_addr,
  output word_t             ra_data,
  output chk_t              ra_chk,
  output logic              ra_valid,
  input  logic [ADDR_W-1:0] rb_addr,
  output word_t             rb_data,
  output chk_t              rb_chk,
  output logic              rb_valid
);
  word_t            data_mem [DEPTH];
  chk_t             chk_mem  [DEPTH];
  logic [DEPTH-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (wa_en) begin
      data_mem[wa_addr] <= wa_data;
      if (!wa_keep_chk) chk_mem[wa_addr] <= wa_chk;
    end else if (wb_en) begin
      data_mem[wb_addr] <= wb_data;
      chk_mem[wb_addr]  <= wb_chk;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     valid_q <= '0;
    else if (wa_en) valid_q[wa_addr] <= 1'b1;
  end

  assign ra_data  = data_mem[ra_addr];
  assign ra_chk   = chk_mem[ra_addr];
  assign ra_valid = valid_q[ra_addr];
  assign rb_data  = data_mem[rb_addr];
  assign rb_chk   = chk_mem[rb_addr];
  assign rb_valid = valid_q[rb_addr];
endmodule

// File: rtl/ecc_err_flag.sv
module ecc_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_sbe,
  input  logic rd_go,
  input  logic rd_clean,
  input  logic rd_single,
  input  logic rd_multi,
  input  logic rd_invalid,
  input  logic scr_go,
  input  logic scr_single,
  input  logic scr_multi,
  input  logic scr_invalid,
  output logic flag_q
);
  function automatic logic selected(input logic m, input logic s, input logic u, input logic inv);
    return inv || (m ? s : u);
  endfunction

  logic set_rd, set_scr, clr_rd;

  assign set_rd  = rd_go  && selected(mode_sbe, rd_single,  rd_multi,  rd_invalid);
  assign set_scr = scr_go && selected(mode_sbe, scr_single, scr_multi, scr_invalid);
  assign clr_rd  = rd_go  && rd_clean;

  always_ff @(posedge clk) begin
    if (!rst_n)                flag_q <= 1'b0;
    else if (set_rd || set_scr) flag_q <= 1'b1;
    else if (clr_rd)           flag_q <= 1'b0;
  end
endmodule

// File: rtl/ecc_word_mem.sv
module ecc_word_mem
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mode_sbe,
  input  logic              cfg_bypass,
  input  logic              req_en,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rd_data,
  output logic              err_flag,
  input  logic              scr_en,
  input  logic [ADDR_W-1:0] scr_addr,
  output logic              scr_fixed,
  output logic              scr_fault
);
  // named internal events, also observed by the checker
  logic  wr_go, rd_go, byp_rd, scr_go;
  logic  rd_clean, rd_single, rd_multi, rd_invalid;
  logic  scr_clean, scr_single, scr_multi, scr_invalid;
  word_t ra_data, rb_data, rd_fix, scr_fix;
  chk_t  ra_chk, rb_chk;
  logic  ra_valid, rb_valid;

  assign wr_go  = req_en && req_wr;
  assign rd_go  = req_en && !req_wr && !cfg_bypass;
  assign byp_rd = req_en && !req_wr && cfg_bypass;
  assign scr_go = scr_en && !req_en && !cfg_bypass;

  ecc_word_store #(.ADDR_W(ADDR_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wa_en      (wr_go),
    .wa_addr    (req_addr),
    .wa_data    (req_wdata),
    .wa_chk     (ecc_check(req_wdata)),
    .wa_keep_chk(cfg_bypass),
    .wb_en      (scr_go && scr_single),
    .wb_addr    (scr_addr),
    .wb_data    (scr_fix),
    .wb_chk     (ecc_check(scr_fix)),
    .ra_addr    (req_addr),
    .ra_data    (ra_data),
    .ra_chk     (ra_chk),
    .ra_valid   (ra_valid),
    .rb_addr    (scr_addr),
    .rb_data    (rb_data),
    .rb_chk     (rb_chk),
    .rb_valid   (rb_valid)
  );

  ecc_word_decode u_dec_rd (
    .st_data    (ra_data),
    .st_chk     (ra_chk),
    .st_valid   (ra_valid),
    .fix_data   (rd_fix),
    .evt_clean  (rd_clean),
    .evt_single (rd_single),
    .evt_multi  (rd_multi),
    .evt_invalid(rd_invalid)
  );

  ecc_word_decode u_dec_scr (
    .st_data    (rb_data),
    .st_chk     (rb_chk),
    .st_valid   (rb_valid),
    .fix_data   (scr_fix),
    .evt_clean  (scr_clean),
    .evt_single (scr_single),
    .evt_multi  (scr_multi),
    .evt_invalid(scr_invalid)
  );

  ecc_err_flag u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sbe   (cfg_mode_sbe),
    .rd_go      (rd_go),
    .rd_clean   (rd_clean),
    .rd_single  (rd_single),
    .rd_multi   (rd_multi),
    .rd_invalid (rd_invalid),
    .scr_go     (scr_go),
    .scr_single (scr_single),
    .scr_multi  (scr_multi),
    .scr_invalid(scr_invalid),
    .flag_q     (err_flag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data   <= '0;
      scr_fixed <= 1'b0;
      scr_fault <= 1'b0;
    end else begin
      if (rd_go)       rd_data <= rd_fix;
      else if (byp_rd) rd_data <= ra_valid ? ra_data : '0;
      scr_fixed <= scr_go && scr_single;
      scr_fault <= scr_go && !scr_clean && !scr_single;
    end
  end
endmodule

// File: rtl/ecc_word_mem_chk.sv
module ecc_word_mem_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_mode_sbe,
  input logic cfg_bypass,
  input logic req_en,
  input logic scr_en,
  input logic rd_go,
  input logic rd_clean,
  input logic rd_single,
  input logic rd_multi,
  input logic rd_invalid,
  input logic err_flag,
  input logic scr_fixed,
  input logic scr_fault
);
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !(rd_go && rd_clean) |=> err_flag);

  a_r6_clean_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go && rd_clean |=> !err_flag);

  a_r5_invalid_raises: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go && rd_invalid |=> err_flag);

  a_r3_multi_raises: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go && !cfg_mode_sbe && rd_multi |=> err_flag);

  a_r4_single_raises: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go && cfg_mode_sbe && rd_single |=> err_flag);

  a_r10_scrub_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    scr_en && (req_en || cfg_bypass) |=> !scr_fixed && !scr_fault);

  a_r8_outcome_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(scr_fixed && scr_fault));

  a_r2_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |-> $countones({rd_clean, rd_single, rd_multi, rd_invalid}) == 1);
endmodule

bind ecc_word_mem ecc_word_mem_chk u_chk (.*);

// File: tb/sim_ecc_word_mem.sv
`timescale 1ns/1ps
module sim_ecc_word_mem;
  localparam int AW = 6;
  localparam int DEPTH = 2 ** AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_mode_sbe = 1'b0, cfg_bypass = 1'b0;
  logic          req_en = 1'b0, req_wr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [31:0]   rd_data;
  logic          err_flag;
  logic          scr_en = 1'b0;
  logic [AW-1:0] scr_addr = '0;
  logic          scr_fixed, scr_fault;

  always #10 clk = ~clk;

  ecc_word_mem #(.ADDR_W(AW)) u0 (.*);

  // behavioural reference
  logic [31:0] enc_d [DEPTH];
  logic [31:0] raw_d [DEPTH];
  bit          vld   [DEPTH];
  logic [31:0] e_rd;
  logic        e_flag, e_fix, e_bad;
  string       cur_tag;
  int          n_chk = 0, n_err = 0;

  // 0 unwritten, 1 clean, 2 single, 3 double
  function automatic int kind(input int a);
    int w;
    if (!vld[a]) return 0;
    w = $countones(raw_d[a] ^ enc_d[a]);
    return (w == 0) ? 1 : (w == 1) ? 2 : 3;
  endfunction

  task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", cur_tag, what, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic wr, input int a, input logic [31:0] wd,
                      input logic sen, input int sa, input logic mode, input logic byp,
                      input string tag);
    int k;
    @(negedge clk);
    cmp("rd_data", rd_data, e_rd);
    cmp("err_flag", {31'b0, err_flag}, {31'b0, e_flag});
    cmp("scr_fixed", {31'b0, scr_fixed}, {31'b0, e_fix});
    cmp("scr_fault", {31'b0, scr_fault}, {31'b0, e_bad});
    req_en = en; req_wr = wr; req_addr = AW'(a); req_wdata = wd;
    scr_en = sen; scr_addr = AW'(sa); cfg_mode_sbe = mode; cfg_bypass = byp;
    cur_tag = tag;
    e_fix = 1'b0; e_bad = 1'b0;
    if (en && wr) begin
      raw_d[a] = wd;
      if (!byp) enc_d[a] = wd;
      vld[a] = 1'b1;
    end else if (en) begin
      if (byp) e_rd = vld[a] ? raw_d[a] : 32'h0;
      else begin
        k = kind(a);
        case (k)
          0: begin e_rd = 32'h0; e_flag = 1'b1; end
          1: begin e_rd = raw_d[a]; e_flag = 1'b0; end
          2: begin e_rd = enc_d[a]; if (mode) e_flag = 1'b1; end
          default: begin e_rd = raw_d[a]; if (!mode) e_flag = 1'b1; end
        endcase
      end
    end
    if (sen && !en && !byp) begin
      k = kind(sa);
      case (k)
        0: begin e_bad = 1'b1; e_flag = 1'b1; end
        1: ;
        2: begin e_fix = 1'b1; raw_d[sa] = enc_d[sa]; if (mode) e_flag = 1'b1; end
        default: begin e_bad = 1'b1; if (!mode) e_flag = 1'b1; end
      endcase
    end
    @(posedge clk);
  endtask

  task automatic wr_n(input int a, input logic [31:0] d, input string t);
    step(1, 1, a, d, 0, 0, 0, 0, t);
  endtask
  task automatic wr_b(input int a, input logic [31:0] d, input string t);
    step(1, 1, a, d, 0, 0, 0, 1, t);
  endtask
  task automatic rd(input int a, input logic m, input string t);
    step(1, 0, a, 0, 0, 0, m, 0, t);
  endtask
  task automatic rd_b(input int a, input string t);
    step(1, 0, a, 0, 0, 0, 0, 1, t);
  endtask
  task automatic idle(input string t);
    step(0, 0, 0, 0, 0, 0, 0, 0, t);
  endtask
  task automatic scrub(input int sa, input logic m, input logic byp, input string t);
    step(0, 0, 0, 0, 1, sa, m, byp, t);
  endtask

  initial begin
    #4_000_000;
    n_err++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin vld[i] = 1'b0; enc_d[i] = '0; raw_d[i] = '0; end
    e_rd = '0; e_flag = 1'b0; e_fix = 1'b0; e_bad = 1'b0;
    cur_tag = "R6_reset";
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    idle("R6_reset");
    // R5: unwritten location
    rd(3, 0, "R5_unwritten_m0");
    idle("R5_zero_data");
    // R1 and R6 clear
    wr_n(3, 32'hA5A5_1234, "R1_write");
    rd(3, 0, "R1_read_clean");
    idle("R6_cleared");
    // R2 / R3: single error in mode 0 leaves flag alone
    wr_n(5, 32'hDEAD_BEEF, "R1_write5");
    wr_b(5, 32'hDEAD_BEEF ^ 32'h0000_0100, "R7_inject1");
    rd(5, 0, "R2_corrected");
    // R3 / R11: double error
    wr_n(6, 32'h0F0F_F0F0, "R1_write6");
    wr_b(6, 32'h0F0F_F0F0 ^ 32'h8000_0001, "R7_inject2");
    rd(6, 0, "R3_double_m0");
    idle("R11_raw_data");
    // R6: sticky through idle and non-selected events
    idle("R6_hold_idle");
    rd(5, 0, "R6_hold_single_m0");
    rd(3, 0, "R6_clear_by_clean");
    // R4: mode 1
    rd(5, 1, "R4_single_m1");
    rd(3, 1, "R6_clear_m1");
    rd(6, 1, "R4_double_m1_ignored");
    idle("R4_flag_low");
    rd(9, 1, "R5_unwritten_m1");
    rd(3, 1, "R6_clear2");
    // R7: bypass read raw, flag unchanged
    rd(9, 0, "R5_set_again");
    rd_b(5, "R7_raw_read");
    idle("R7_flag_held");
    rd(3, 0, "R6_clear3");
    // R10: blocked scrubs
    step(1, 0, 3, 0, 1, 5, 1, 0, "R10_scrub_with_req");
    scrub(5, 1, 1, "R10_scrub_in_bypass");
    rd_b(5, "R10_not_repaired");
    idle("R10_check");
    // R8: scrub repair in mode 1
    scrub(5, 1, 0, "R8_scrub_fix");
    idle("R8_pulse");
    rd(5, 1, "R8_clean_after");
    rd_b(5, "R8_raw_repaired");
    idle("R8_check");
    // R9: scrub of double and unwritten
    scrub(6, 0, 0, "R9_scrub_double");
    idle("R9_pulse");
    rd_b(6, "R9_unchanged");
    rd(3, 0, "R6_clear4");
    scrub(12, 1, 0, "R9_scrub_unwritten");
    idle("R9_pulse2");
    rd(3, 0, "R6_clear5");
    // R1 patterns
    for (int i = 0; i < 16; i++) wr_n(16 + i, 32'h1357_9BDF * (i + 1) ^ (32'h1 << i), "R1_fill");
    for (int i = 0; i < 16; i++) rd(16 + i, i[0], "R1_readback");
    // R2: every data bit position
    for (int b = 0; b < 32; b++) begin
      wr_n(7, 32'hC3A5_5A3C, "R2_base");
      wr_b(7, 32'hC3A5_5A3C ^ (32'h1 << b), "R2_flip");
      rd(7, 0, "R2_each_bit");
    end
    // R11 in mode 1, R3 again
    wr_b(7, 32'hC3A5_5A3C ^ 32'h0000_0300, "R11_inject");
    rd(7, 1, "R11_double_raw");
    rd(7, 0, "R3_double_sets");
    idle("R3_final");
    idle("R3_final2");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule